// File: doc/BRIEF.md
# Mapper descriptor matching engine

This block decides which simple cartridge mapper type best explains a measured behaviour score. The score is 13 bytes wide: one byte for nametable mirroring, four bytes for the 8 KB program windows and eight bytes for the 1 KB character windows. Each bit of a score byte marks a bank-select bit that was seen to affect that window. A descriptor table of up to 32 slots, 32 bytes per slot, sits in an external byte-wide memory with one cycle of read latency. The engine walks this table slot by slot. For each slot it fetches the mapper number, the packed bank configuration and the 13 bitmap bytes at descriptor offsets 3 to 15. It then judges whether the slot is a candidate and keeps the best candidate found so far.

A `start` pulse launches a walk. The engine finishes when it reads a zero mapper number or when the last slot has been judged. It then pulses `done` and holds the winning mapper number, a found flag and the number of candidates until the next `start`. When more than one slot qualifies, the winner is the slot whose configuration allows the largest ROM image. If two slots give the same image size, the lower slot wins.

The controller has five states:
- `ST_IDLE` waits for `start`, then moves to `ST_SCAN`.
- `ST_SCAN` issues the sixteen reads of one slot. It moves to `ST_DONE` if the returned mapper byte is zero, and otherwise to `ST_DRAIN` after offset 15 has been issued.
- `ST_DRAIN` takes in the last byte and always moves to `ST_JUDGE`.
- `ST_JUDGE` scores the slot. It moves to `ST_DONE` after the last slot and otherwise back to `ST_SCAN` for the next slot.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `desc_match_engine`

## Requirements
- R1: While reset is held and right after it is released, `done`, `found`, `rd_en`, `mapper_id` and `cand_count` are all zero.
- R2: A walk reads offsets 0 to 15 of each slot in ascending order, one read per cycle, at address slot*32+offset. The first read is at address 0 in the cycle after `start` is accepted. Offsets 16 to 31 are never read. Read data is expected one cycle after `rd_en`.
- R3: A slot whose offset-0 byte is zero ends the walk. That slot and every slot after it are not judged. An empty table gives `found`=0, `mapper_id`=0 and `cand_count`=0.
- R4: A slot is a candidate when, for each offset k in 3..15 whose score byte is nonzero, the score byte and the descriptor byte share at least one set bit and the score byte has no set bit where the descriptor byte is clear. Score byte i (bits 8i+7..8i of `score`) pairs with descriptor offset i+3.
- R5: A score byte of zero puts no condition on its descriptor byte.
- R6: `cand_count` equals the number of candidate slots judged in the walk. At `done`, `found` is 1 exactly when `cand_count` is nonzero.
- R7: The winner is the candidate with the largest image size in KB. Image size is P·2^p + C·2^c. P comes from configuration bits 3:2 (00→32, 01→16, 11→8, 10→0). C comes from configuration bits 7:4 (0000→0, 0001→8, 001x→4, 01xx→2, 1xxx→1). p is the largest popcount among offsets 4..7, and c is the largest popcount among offsets 8..15.
- R8: Between candidates of equal image size, the lower-numbered slot wins.
- R9: `done` is high for exactly one cycle. It comes 18·n+2 clock edges after the edge that accepts `start` when slot n is the terminator, and 18·32 edges after that edge when no terminator exists. The results stay stable until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a walk when the engine is idle |
| score | input | 104 | Behaviour score; byte i pairs with descriptor offset i+3; held stable during a walk |
| rd_en | output | 1 | Descriptor memory read strobe |
| rd_addr | output | 10 | Descriptor memory byte address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | At least one candidate was found |
| mapper_id | output | 8 | Mapper number of the winning slot, 0 if none |
| cand_count | output | 6 | Number of candidate slots |

## Verification
The bench sweeps every pairing of small score and descriptor patterns at each of the 13 compared offsets, with single bits shifted across the byte. A design that tested only overlap would accept descriptors that miss score bits. A design that tested only containment would accept descriptors sharing nothing with the score. A design that did not exempt zero score bytes would reject valid slots.

A second sweep runs all 256 configuration bytes against a fixed rival slot. This exposes wrong bank-size decoding, including the undefined program size. It also catches ties settled in favour of the later slot.

Tables ending at slot 0, in the middle, or with no terminator at all check the following at the ports:
- that nothing past the terminator is counted;
- the exact completion latency;
- that text bytes are never fetched.

// File: rtl/desc_match_pkg.sv
package desc_match_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_JUDGE,
        ST_DONE
    } walk_state_t;

    localparam int SCORE_BYTES = 13;
    localparam int FIELD_FIRST = 3;
    localparam int FETCH_BYTES = 16;
    localparam int PRG_FIRST   = 4;
    localparam int PRG_LAST    = 7;
    localparam int CHR_FIRST   = 8;
    localparam int CHR_LAST    = 15;
    localparam int SLOT_BYTES  = 32;

endpackage

// File: rtl/desc_byte_judge.sv
module desc_byte_judge (
    input  logic [7:0] score_byte,
    input  logic [7:0] desc_byte,
    output logic       byte_ok,
    output logic [3:0] desc_ones
);

    logic overlap;
    logic stray;

    assign overlap = (score_byte & desc_byte) != 8'h00;
    assign stray   = (score_byte & ~desc_byte) != 8'h00;
    // R4 / R5: a zero score byte is always acceptable
    assign byte_ok = (score_byte == 8'h00) || (overlap && !stray);

    always_comb begin
        desc_ones = '0;
        for (int i = 0; i < 8; i++) begin
            desc_ones = desc_ones + {3'b000, desc_byte[i]};
        end
    end

endmodule

// File: rtl/desc_image_size.sv
module desc_image_size #(
    parameter int SIZE_W = 16
) (
    input  logic [7:0]        cfg,
    input  logic [3:0]        prg_bits,
    input  logic [3:0]        chr_bits,
    output logic [SIZE_W-1:0] size_kb
);

    logic [SIZE_W-1:0] prg_kb;
    logic [SIZE_W-1:0] chr_kb;

    always_comb begin
        unique case (cfg[3:2])
            2'b00:   prg_kb = SIZE_W'(32);
            2'b01:   prg_kb = SIZE_W'(16);
            2'b11:   prg_kb = SIZE_W'(8);
            default: prg_kb = '0;
        endcase
        casez (cfg[7:4])
            4'b0000: chr_kb = '0;
            4'b0001: chr_kb = SIZE_W'(8);
            4'b001?: chr_kb = SIZE_W'(4);
            4'b01??: chr_kb = SIZE_W'(2);
            default: chr_kb = SIZE_W'(1);
        endcase
        size_kb = (prg_kb << prg_bits) + (chr_kb << chr_bits);
    end

endmodule

// File: rtl/desc_match_engine.sv
module desc_match_engine
    import desc_match_pkg::*;
#(
    parameter  int NUM_SLOTS = 32,
    parameter  int SIZE_W    = 16,
    localparam int SLOT_AW   = $clog2(NUM_SLOTS),
    localparam int ADDR_W    = SLOT_AW + $clog2(SLOT_BYTES),
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [8*SCORE_BYTES-1:0] score,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [7:0]               rd_data,
    output logic                     done,
    output logic                     found,
    output logic [7:0]               mapper_id,
    output logic [CNT_W-1:0]         cand_count
);

    localparam int OFF_W = $clog2(FETCH_BYTES);

    walk_state_t        state, state_nx;
    logic [SLOT_AW-1:0] slot;
    logic [OFF_W-1:0]   off;
    logic               rsp_vld;
    logic [OFF_W-1:0]   rsp_off;
    logic [7:0]         cur_mapper;
    logic [7:0]         cur_cfg;
    logic               match_ok;
    logic [3:0]         prg_max;
    logic [3:0]         chr_max;
    logic [SIZE_W-1:0]  best_size;
    logic [SIZE_W-1:0]  slot_size;
    logic               byte_ok;
    logic [3:0]         byte_ones;
    logic               term_seen;

    // score bytes laid out by descriptor offset; offsets below FIELD_FIRST are padding
    logic [7:0] score_arr [FETCH_BYTES];
    for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_score
        if (k >= FIELD_FIRST) begin : g_live
            assign score_arr[k] = score[(k-FIELD_FIRST)*8 +: 8];
        end else begin : g_pad
            assign score_arr[k] = 8'h00;
        end
    end

    desc_byte_judge u_judge (
        .score_byte (score_arr[rsp_off]),
        .desc_byte  (rd_data),
        .byte_ok    (byte_ok),
        .desc_ones  (byte_ones)
    );

    desc_image_size #(.SIZE_W(SIZE_W)) u_size (
        .cfg      (cur_cfg),
        .prg_bits (prg_max),
        .chr_bits (chr_max),
        .size_kb  (slot_size)
    );

    assign rd_en     = (state == ST_SCAN);
    assign rd_addr   = {slot, 1'b0, off};
    assign done      = (state == ST_DONE);
    assign term_seen = rsp_vld && (rsp_off == '0) && (rd_data == 8'h00);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SCAN;
            ST_SCAN: begin
                if (term_seen)                                state_nx = ST_DONE;
                else if (off == OFF_W'(FETCH_BYTES - 1))      state_nx = ST_DRAIN;
            end
            ST_DRAIN: state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = (slot == SLOT_AW'(NUM_SLOTS - 1)) ? ST_DONE : ST_SCAN;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot       <= '0;
            off        <= '0;
            rsp_vld    <= 1'b0;
            rsp_off    <= '0;
            cur_mapper <= '0;
            cur_cfg    <= '0;
            match_ok   <= 1'b1;
            prg_max    <= '0;
            chr_max    <= '0;
            best_size  <= '0;
            found      <= 1'b0;
            mapper_id  <= '0;
            cand_count <= '0;
        end else begin
            rsp_vld <= (state == ST_SCAN);
            rsp_off <= off;
            if (state == ST_IDLE && start) begin
                slot       <= '0;
                off        <= '0;
                match_ok   <= 1'b1;
                prg_max    <= '0;
                chr_max    <= '0;
                best_size  <= '0;
                found      <= 1'b0;
                mapper_id  <= '0;
                cand_count <= '0;
            end
            if (state == ST_SCAN) off <= off + 1'b1;
            if (rsp_vld && (state == ST_SCAN || state == ST_DRAIN)) begin
                if (rsp_off == OFF_W'(0)) cur_mapper <= rd_data;
                if (rsp_off == OFF_W'(1)) cur_cfg    <= rd_data;
                if (rsp_off >= OFF_W'(FIELD_FIRST)) match_ok <= match_ok & byte_ok;
                if (rsp_off >= OFF_W'(PRG_FIRST) && rsp_off <= OFF_W'(PRG_LAST)
                    && byte_ones > prg_max) prg_max <= byte_ones;
                if (rsp_off >= OFF_W'(CHR_FIRST) && rsp_off <= OFF_W'(CHR_LAST)
                    && byte_ones > chr_max) chr_max <= byte_ones;
            end
            if (state == ST_JUDGE) begin
                if (match_ok) begin
                    cand_count <= cand_count + 1'b1;
                    if (!found || slot_size > best_size) begin   // R8: strict, earlier wins ties
                        found     <= 1'b1;
                        mapper_id <= cur_mapper;
                        best_size <= slot_size;
                    end
                end
                slot     <= slot + 1'b1;
                match_ok <= 1'b1;
                prg_max  <= '0;
                chr_max  <= '0;
            end
        end
    end

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (rd_en && rd_addr == '0));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[OFF_W-1:0] != '0) |-> ($past(rd_en) && rd_addr == $past(rd_addr) + 1'b1));

    p_term_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && term_seen) |=> (done && !rd_en));

    p_found_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (found == (cand_count != '0)));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_count <= CNT_W'(NUM_SLOTS));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(mapper_id) && $stable(found) && $stable(cand_count)));

endmodule

// File: tb/desc_match_engine_bench.sv
module desc_match_engine_bench;

    localparam int NS = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [103:0] score = '0;
    logic         rd_en;
    logic [9:0]   rd_addr;
    logic [7:0]   rd_data;
    logic         done;
    logic         found;
    logic [7:0]   mapper_id;
    logic [5:0]   cand_count;

    logic [7:0]  mem [1024];
    int          checks = 0;
    int          errors = 0;
    int          rd_idx = 0;
    int          rd_bad = 0;
    int          cycles = 0;
    bit          finished = 1'b0;
    logic [31:0] seed = 32'h1234_5679;

    desc_match_engine u_desc_match_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .score(score),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .found(found), .mapper_id(mapper_id), .cand_count(cand_count)
    );

    always #10 clk = ~clk;

    always @(posedge clk) rd_data <= mem[rd_addr];

    // R2 read-order monitor: read number i must hit slot i/16, offset i%16
    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr != 10'(((rd_idx / 16) * 32) + (rd_idx % 16))) rd_bad++;
            rd_idx++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int prg_kb(input logic [1:0] pp);
        if (pp == 2'd0) return 32;
        if (pp == 2'd1) return 16;
        if (pp == 2'd3) return 8;
        return 0;
    endfunction

    function automatic int chr_kb(input logic [3:0] c);
        if (c == 0) return 0;
        if (c == 1) return 8;
        if (c < 4)  return 4;
        if (c < 8)  return 2;
        return 1;
    endfunction

    function automatic void ref_model(input logic [103:0] sc, output int term,
                                      output logic f, output logic [7:0] m, output int cnt);
        int b, pb, cb, sz, best;
        bit ok;
        logic [7:0] sv, dv;
        f = 1'b0; m = 8'h00; cnt = 0; best = 0; term = NS;
        for (int s = 0; s < NS; s++) begin
            b = s * 32;
            if (mem[b] == 8'h00) begin
                term = s;
                break;
            end
            ok = 1'b1; pb = 0; cb = 0;
            for (int k = 3; k < 16; k++) begin
                sv = sc[(k-3)*8 +: 8];
                dv = mem[b+k];
                if (sv != 0 && (((sv & dv) == 0) || ((sv & ~dv) != 0))) ok = 1'b0;
                if (k >= 4 && k <= 7 && $countones(dv) > pb) pb = $countones(dv);
                if (k >= 8 && $countones(dv) > cb) cb = $countones(dv);
            end
            sz = prg_kb(mem[b+1][3:2]) * (1 << pb) + chr_kb(mem[b+1][7:4]) * (1 << cb);
            if (ok) begin
                cnt++;
                if (!f || sz > best) begin
                    f = 1'b1; m = mem[b]; best = sz;
                end
            end
        end
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    task automatic run(input logic [103:0] sc, input string req);
        int term, cnt, cyc, exp_cyc, exp_rd;
        logic f;
        logic [7:0] m;
        ref_model(sc, term, f, m, cnt);
        exp_cyc = (term < NS) ? 18 * term + 3 : 18 * NS + 1;
        exp_rd  = (term < NS) ? 16 * term + 2 : 16 * NS;
        score  = sc;
        rd_idx = 0;
        rd_bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "found", found, f);
        chk(req, "mapper_id", mapper_id, m);
        chk("R6", "cand_count", cand_count, cnt);
        chk("R9", "done latency", cyc, exp_cyc);
        chk("R2", "read count", rd_idx, exp_rd);
        chk("R2", "read order errors", rd_bad, 0);
        repeat (3) @(negedge clk);
        chk("R9", "done pulse", done, 0);
        chk("R9", "held mapper_id", mapper_id, m);
        chk("R9", "held cand_count", cand_count, cnt);
    endtask

    task automatic build_rand(input logic [103:0] sc, input int term);
        int b;
        bit cand;
        clear_mem();
        for (int s = 0; s < NS; s++) begin
            b = s * 32;
            mem[b]   = (s == term) ? 8'h00 : 8'((nxt() % 255) + 1);
            mem[b+1] = 8'(nxt());
            cand = (nxt() % 3) != 0;
            for (int k = 3; k < 16; k++)
                mem[b+k] = cand ? (sc[(k-3)*8 +: 8] | (8'(nxt()) & 8'(nxt()))) : 8'(nxt());
            for (int k = 16; k < 32; k++) mem[b+k] = 8'(nxt());
        end
    endtask

    initial begin
        logic [103:0] sc;
        logic [7:0]   sb, db;
        int           term;
        clear_mem();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        chk("R1", "found in reset", found, 0);
        chk("R1", "rd_en in reset", rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mapper_id after reset", mapper_id, 0);
        chk("R1", "cand_count after reset", cand_count, 0);
        chk("R1", "rd_en after reset", rd_en, 0);

        // R3: empty table
        run(104'h0f, "R3");

        // R4 / R5: per-offset sweep of small score/descriptor patterns
        for (int p = 0; p < 13; p++) begin
            for (int s = 0; s < 8; s++) begin
                for (int d = 0; d < 8; d++) begin
                    clear_mem();
                    mem[0] = 8'h21;
                    mem[1] = 8'h14;
                    sb = 8'(s << (p % 6));
                    db = 8'(d << (p % 6));
                    mem[3+p] = db;
                    sc = '0;
                    sc[p*8 +: 8] = sb;
                    run(sc, (s == 0) ? "R5" : "R4");
                end
            end
        end

        // R3: terminator in the middle, valid candidates after it
        sc = 104'h0102_0408_1020_4080_0102_0408_10;
        clear_mem();
        for (int s = 0; s < 8; s++) begin
            mem[s*32]   = (s == 5) ? 8'h00 : 8'(s + 1);
            mem[s*32+1] = 8'h04;
            for (int k = 3; k < 16; k++) mem[s*32+k] = sc[(k-3)*8 +: 8];
        end
        run(sc, "R3");

        // R8: identical candidates, the earlier slot wins
        clear_mem();
        for (int s = 0; s < 2; s++) begin
            mem[s*32]   = 8'(8'h40 + s);
            mem[s*32+1] = 8'h14;
            mem[s*32+4] = 8'h03;
        end
        run(104'h0300, "R8");
        chk("R8", "tie winner", mapper_id, 8'h40);

        // R7: every configuration byte against a fixed rival in slot 0
        for (int c = 0; c < 256; c++) begin
            clear_mem();
            mem[0] = 8'h11; mem[1] = 8'h24; mem[4] = 8'h03; mem[8] = 8'h01;
            mem[32] = 8'h22; mem[33] = 8'(c); mem[36] = 8'h03; mem[40] = 8'h01;
            run(104'h0300, "R7");
        end

        // R6 / R7 / R8 / R9: random tables, with and without a terminator
        for (int t = 0; t < 60; t++) begin
            sc = '0;
            for (int i = 0; i < 13; i++)
                if (nxt() % 2 == 0) sc[i*8 +: 8] = 8'(nxt()) & 8'(nxt());
            term = (t % 2 == 0) ? NS : int'(nxt() % NS);
            build_rand(sc, term);
            run(sc, "R7");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule